// File: doc/BRIEF.md
# Interrupt Redirection Register Window

This block is the register front end of an interrupt router. Software reaches all of its state through a small memory-mapped window. An index register picks an internal register, and a data port then reads or writes that register 32 bits at a time. The internal registers are an identification register, a version register, an arbitration register and a table of redirection entries of 64 bits each. Each entry is reached as two 32-bit halves. A third offset takes end-of-interrupt writes and passes the vector straight on to external logic.

The routing logic and the end-of-interrupt walk sit outside this block. The block gives them the full entry table on a flat bus. It raises a one-cycle `rescan_o` pulse after every accepted table write, and a one-cycle `eoi_valid_o` strobe carrying the written vector. The external logic owns the two status bits of each entry, delivery status and remote IRR. It updates them through a per-pin strobe. Bus writes can never change those two bits. Remote IRR is held at zero whenever an entry is set to edge trigger.

Top module: `irq_redir_regs`

## Requirements
- R1: After reset `rdata_o` is 0, the ID is 0, the index register is 0, every entry reads 0x0000_0000_0001_0000 (only the mask bit, bit 16, set), and `rescan_o` and `eoi_valid_o` are low.
- R2: A write of any size to offset 0x00 loads `wdata_i[7:0]` into the index register. A read of offset 0x00 returns the index register in bits 7:0.
- R3: Only `addr_i[7:0]` is decoded, so offset 0x110 acts as offset 0x10 and offset 0xF00 acts as offset 0x00.
- R4: An access to the data port (offset 0x10) with `size_i` other than 4 bytes does nothing. A read of that kind returns 0.
- R5: Index 0x00 holds a 4-bit ID that is written from `wdata_i[27:24]`. Reads of index 0x00 and of index 0x02 both return the ID at bits 27:24. Writes to index 0x01 and index 0x02 are ignored.
- R6: A read of index 0x01 returns VERSION in bits 7:0 and (NPINS-1) in bits 23:16. With the defaults this is 0x0017_0020.
- R7: Index 0x10+2k reaches bits 31:0 of entry k, and index 0x11+2k reaches bits 63:32. Entries with k >= NPINS read 0 and ignore writes.
- R8: Bus writes to an entry keep bit 12 (delivery status) and bit 14 (remote IRR) at their previous values. When `ro_we_i[p]` is high, these bits of entry p load from `ro_dlv_i[p]` and `ro_rirr_i[p]`.
- R9: Bit 14 of an entry is 0 in every cycle in which its bit 15 (trigger mode, 0 means edge) is 0.
- R10: `rescan_o` pulses for exactly one cycle, in the cycle after each 4-byte data-port write to an in-range entry. It stays low at all other times.
- R11: A 4-byte write to offset 0x40 gives `eoi_valid_o` high for one cycle in the next cycle, with `eoi_vector_o` equal to `wdata_i[7:0]`. This happens only when VERSION is 0x20. Writes of other sizes give no strobe.
- R12: Read data is registered and appears in the cycle after `rd_en_i`. It holds until the next read. Offsets other than 0x00 and 0x10 read 0, as do index values that map to nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Write strobe |
| rd_en_i | input | 1 | Read strobe |
| addr_i | input | ADDR_W | Byte offset of the access |
| size_i | input | 3 | Access width in bytes |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Registered read data |
| ro_we_i | input | NPINS | Per-pin strobe to update the status bits |
| ro_dlv_i | input | NPINS | New delivery status per pin |
| ro_rirr_i | input | NPINS | New remote IRR per pin |
| entry_o | output | 64*NPINS | All entries, entry k at bits 64k+63:64k |
| rescan_o | output | 1 | One-cycle pulse after a table write |
| eoi_valid_o | output | 1 | End-of-interrupt strobe |
| eoi_vector_o | output | 8 | Vector of the end-of-interrupt write |

## Verification
The bench tries to set the status bits through the bus, both on level entries and on edge entries that external logic has marked pending. A design that merged the status bits from write data would show them set or cleared on readback. A design that skipped the edge fix would leave remote IRR set on an edge entry. The bench also exercises index boundaries: the last upper half (0x3F), the first out-of-range index (0x40) and odd-versus-even halves. An off-by-one in the index would corrupt a neighbouring entry or raise a spurious `rescan_o`. Other cases are 2-byte data-port accesses, aliased high address bits, 1-byte end-of-interrupt writes and writes to the version and arbitration indices. Each of these would show up as a changed register, a nonzero read or a stray strobe.

// File: rtl/irq_redir_pkg.sv
package irq_redir_pkg;
  localparam logic [7:0] OFF_SEL = 8'h00;
  localparam logic [7:0] OFF_WIN = 8'h10;
  localparam logic [7:0] OFF_EOI = 8'h40;

  localparam logic [7:0] IDX_ID   = 8'h00;
  localparam logic [7:0] IDX_VER  = 8'h01;
  localparam logic [7:0] IDX_ARB  = 8'h02;
  localparam logic [7:0] IDX_TBL  = 8'h10;

  localparam int ID_LSB    = 24;
  localparam int ID_W      = 4;
  localparam int NENT_LSB  = 16;
  localparam int DLV_BIT   = 12;
  localparam int RIRR_BIT  = 14;
  localparam int TRIG_BIT  = 15;

  localparam logic [63:0] ENTRY_RST = 64'h0000_0000_0001_0000;

  typedef enum logic [2:0] {
    RD_ZERO,
    RD_SEL,
    RD_ID,
    RD_VER,
    RD_TBL
  } rd_kind_e;
endpackage

// File: rtl/irq_redir_decode.sv
module irq_redir_decode
  import irq_redir_pkg::*;
#(
  parameter int NPINS = 24,
  parameter logic [7:0] VERSION = 8'h20
) (
  input  logic [7:0] addr_lo_i,
  input  logic [2:0] size_i,
  input  logic       wr_en_i,
  input  logic [7:0] sel_i,
  output logic       sel_we_o,
  output logic       id_we_o,
  output logic       tbl_we_o,
  output logic       tbl_hi_o,
  output logic [6:0] tbl_idx_o,
  output logic       eoi_we_o,
  output rd_kind_e   rd_kind_o
);
  logic       win_ok;
  logic       tbl_hit;
  logic [7:0] rel;

  assign rel       = sel_i - IDX_TBL;
  assign tbl_idx_o = rel[7:1];
  assign tbl_hi_o  = sel_i[0];
  assign tbl_hit   = (sel_i >= IDX_TBL) && (int'(tbl_idx_o) < NPINS);
  assign win_ok    = (addr_lo_i == OFF_WIN) && (size_i == 3'd4);

  assign sel_we_o = wr_en_i && (addr_lo_i == OFF_SEL);
  assign id_we_o  = wr_en_i && win_ok && (sel_i == IDX_ID);
  assign tbl_we_o = wr_en_i && win_ok && tbl_hit;
  assign eoi_we_o = wr_en_i && (addr_lo_i == OFF_EOI) && (size_i == 3'd4)
                    && (VERSION == 8'h20);

  always_comb begin
    rd_kind_o = RD_ZERO;
    if (addr_lo_i == OFF_SEL) begin
      rd_kind_o = RD_SEL;
    end else if (win_ok) begin
      if (sel_i == IDX_ID || sel_i == IDX_ARB) rd_kind_o = RD_ID;
      else if (sel_i == IDX_VER)               rd_kind_o = RD_VER;
      else if (tbl_hit)                        rd_kind_o = RD_TBL;
    end
  end
endmodule

// File: rtl/irq_redir_entry.sv
module irq_redir_entry
  import irq_redir_pkg::*;
(
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        wr_lo_i,
  input  logic        wr_hi_i,
  input  logic [31:0] wdata_i,
  input  logic        ro_we_i,
  input  logic        ro_dlv_i,
  input  logic        ro_rirr_i,
  output logic [63:0] q_o
);
  logic [63:0] nxt;

  always_comb begin
    nxt = q_o;
    if (wr_lo_i) nxt[31:0]  = wdata_i;
    if (wr_hi_i) nxt[63:32] = wdata_i;
    // status bits never come from the bus
    nxt[DLV_BIT]  = ro_we_i ? ro_dlv_i  : q_o[DLV_BIT];
    nxt[RIRR_BIT] = (ro_we_i ? ro_rirr_i : q_o[RIRR_BIT]) & nxt[TRIG_BIT];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) q_o <= ENTRY_RST;
    else         q_o <= nxt;
  end

  a_r9_edge_no_rirr: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !q_o[TRIG_BIT] |-> !q_o[RIRR_BIT]);

  a_r8_dlv_kept: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_lo_i && !ro_we_i) |=> q_o[DLV_BIT] == $past(q_o[DLV_BIT]));
endmodule

// File: rtl/irq_redir_regs.sv
module irq_redir_regs
  import irq_redir_pkg::*;
#(
  parameter int NPINS = 24,
  parameter int ADDR_W = 12,
  parameter logic [7:0] VERSION = 8'h20
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                wr_en_i,
  input  logic                rd_en_i,
  input  logic [ADDR_W-1:0]   addr_i,
  input  logic [2:0]          size_i,
  input  logic [31:0]         wdata_i,
  output logic [31:0]         rdata_o,
  input  logic [NPINS-1:0]    ro_we_i,
  input  logic [NPINS-1:0]    ro_dlv_i,
  input  logic [NPINS-1:0]    ro_rirr_i,
  output logic [64*NPINS-1:0] entry_o,
  output logic                rescan_o,
  output logic                eoi_valid_o,
  output logic [7:0]          eoi_vector_o
);
  localparam logic [7:0] NENT_M1 = 8'(NPINS - 1);

  logic [7:0]      sel_q;
  logic [ID_W-1:0] id_q;
  logic            sel_we, id_we, tbl_we, tbl_hi, eoi_we;
  logic [6:0]      tbl_idx;
  rd_kind_e        rd_kind;
  logic [63:0]     ent [NPINS];
  logic [31:0]     rd_val;
  logic [31:0]     tbl_rd;

  irq_redir_decode #(.NPINS(NPINS), .VERSION(VERSION)) u_dec (
    .addr_lo_i (addr_i[7:0]),
    .size_i    (size_i),
    .wr_en_i   (wr_en_i),
    .sel_i     (sel_q),
    .sel_we_o  (sel_we),
    .id_we_o   (id_we),
    .tbl_we_o  (tbl_we),
    .tbl_hi_o  (tbl_hi),
    .tbl_idx_o (tbl_idx),
    .eoi_we_o  (eoi_we),
    .rd_kind_o (rd_kind)
  );

  for (genvar g = 0; g < NPINS; g++) begin : g_ent
    logic hit;
    assign hit = tbl_we && (int'(tbl_idx) == g);
    irq_redir_entry u_ent (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .wr_lo_i   (hit && !tbl_hi),
      .wr_hi_i   (hit && tbl_hi),
      .wdata_i   (wdata_i),
      .ro_we_i   (ro_we_i[g]),
      .ro_dlv_i  (ro_dlv_i[g]),
      .ro_rirr_i (ro_rirr_i[g]),
      .q_o       (ent[g])
    );
    assign entry_o[64*g +: 64] = ent[g];
  end

  always_comb begin
    tbl_rd = '0;
    for (int i = 0; i < NPINS; i++) begin
      if (int'(tbl_idx) == i) tbl_rd = tbl_hi ? ent[i][63:32] : ent[i][31:0];
    end
  end

  always_comb begin
    unique case (rd_kind)
      RD_SEL:  rd_val = {24'd0, sel_q};
      RD_ID:   rd_val = 32'(id_q) << ID_LSB;
      RD_VER:  rd_val = (32'(NENT_M1) << NENT_LSB) | 32'(VERSION);
      RD_TBL:  rd_val = tbl_rd;
      default: rd_val = '0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sel_q        <= '0;
      id_q         <= '0;
      rdata_o      <= '0;
      rescan_o     <= 1'b0;
      eoi_valid_o  <= 1'b0;
      eoi_vector_o <= '0;
    end else begin
      if (sel_we) sel_q <= wdata_i[7:0];
      if (id_we)  id_q  <= wdata_i[ID_LSB +: ID_W];
      if (rd_en_i) rdata_o <= rd_val;
      rescan_o    <= tbl_we;
      eoi_valid_o <= eoi_we;
      if (eoi_we) eoi_vector_o <= wdata_i[7:0];
    end
  end

  a_r10_rescan_src: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rescan_o |-> $past(wr_en_i && addr_i[7:0] == OFF_WIN && size_i == 3'd4));

  a_r11_eoi_src: assert property (@(posedge clk_i) disable iff (!rst_ni)
    eoi_valid_o |-> $past(wr_en_i && addr_i[7:0] == OFF_EOI && size_i == 3'd4));

  a_r4_narrow_read_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_en_i && addr_i[7:0] == OFF_WIN && size_i != 3'd4) |=> rdata_o == 32'd0);

  a_r5_ver_wr_ignored: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && addr_i[7:0] == OFF_WIN && sel_q == IDX_VER) |=> $stable(id_q));
endmodule

// File: tb/irq_redir_regs_tb_top.sv
module irq_redir_regs_tb_top;
  localparam int NP = 24;

  logic clk = 0;
  logic rst_n = 0;
  always #2 clk = ~clk;

  logic           wr_en = 0, rd_en = 0;
  logic [11:0]    addr = 0;
  logic [2:0]     size = 4;
  logic [31:0]    wdata = 0;
  logic [31:0]    rdata;
  logic [NP-1:0]  ro_we = 0, ro_dlv = 0, ro_rirr = 0;
  logic [64*NP-1:0] entry;
  logic           rescan, eoi_valid;
  logic [7:0]     eoi_vector;

  irq_redir_regs dut_i (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .rd_en_i(rd_en),
    .addr_i(addr), .size_i(size), .wdata_i(wdata), .rdata_o(rdata),
    .ro_we_i(ro_we), .ro_dlv_i(ro_dlv), .ro_rirr_i(ro_rirr),
    .entry_o(entry), .rescan_o(rescan), .eoi_valid_o(eoi_valid),
    .eoi_vector_o(eoi_vector)
  );

  int checks = 0, fails = 0;
  bit done = 0;

  // behavioural reference
  logic [63:0] m_ent [NP];
  int          m_sel, m_id;
  logic [31:0] m_rd;
  bit          m_rescan, m_eoi;
  int          m_vec;
  localparam logic [63:0] ROM = 64'h5000;

  function automatic logic [31:0] m_read(int a, int sz);
    int k;
    if (a == 0) return 32'(m_sel);
    if (a != 16 || sz != 4) return 0;
    if (m_sel == 0 || m_sel == 2) return 32'(m_id) << 24;
    if (m_sel == 1) return 32'h20 | ((NP - 1) << 16);
    if (m_sel < 16) return 0;
    k = (m_sel - 16) / 2;
    if (k >= NP) return 0;
    return (m_sel % 2 == 1) ? m_ent[k][63:32] : m_ent[k][31:0];
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int p = 0; p < NP; p++) m_ent[p] = 64'h10000;
      m_sel = 0; m_id = 0; m_rd = 0; m_rescan = 0; m_eoi = 0; m_vec = 0;
    end else begin
      int a, k;
      logic [63:0] v, old;
      a = int'(addr[7:0]);
      m_rescan = 0; m_eoi = 0; k = -1; v = 0;
      if (rd_en) m_rd = m_read(a, int'(size));
      if (wr_en && a == 16 && size == 4 && m_sel >= 16 && (m_sel - 16) / 2 < NP) begin
        k = (m_sel - 16) / 2;
        old = m_ent[k];
        v = old;
        if (m_sel % 2 == 1) v[63:32] = wdata; else v[31:0] = wdata;
        v = (v & ~ROM) | (old & ROM);
        m_rescan = 1;
      end
      if (wr_en && a == 16 && size == 4 && m_sel == 0) m_id = int'(wdata[27:24]);
      if (wr_en && a == 64 && size == 4) begin m_eoi = 1; m_vec = int'(wdata[7:0]); end
      if (wr_en && a == 0) m_sel = int'(wdata[7:0]);
      for (int p = 0; p < NP; p++) begin
        logic [63:0] e;
        e = (p == k) ? v : m_ent[p];
        if (ro_we[p]) begin e[12] = ro_dlv[p]; e[14] = ro_rirr[p]; end
        if (!e[15]) e[14] = 0;
        m_ent[p] = e;
      end
    end
  end

  task automatic chk(bit ok, string tag, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  // per-cycle comparison against the model
  always @(negedge clk) if (rst_n && !done) begin
    bit eok;
    chk(rdata == m_rd, "R12 rdata", 64'(rdata), 64'(m_rd));
    chk(rescan == m_rescan, "R10 rescan", 64'(rescan), 64'(m_rescan));
    chk(eoi_valid == m_eoi && (!m_eoi || eoi_vector == 8'(m_vec)), "R11 eoi",
        {eoi_valid, eoi_vector}, {1'(m_eoi), 8'(m_vec)});
    eok = 1;
    for (int p = 0; p < NP; p++) if (entry[64*p +: 64] != m_ent[p]) eok = 0;
    chk(eok, "R8 entries", entry[63:0], m_ent[0]);
  end

  task automatic wr(logic [11:0] a, logic [31:0] d, logic [2:0] s = 4);
    @(negedge clk); wr_en = 1; addr = a; wdata = d; size = s;
    @(negedge clk); wr_en = 0; size = 4;
  endtask

  task automatic rd(logic [11:0] a, logic [31:0] exp, string tag, logic [2:0] s = 4);
    @(negedge clk); rd_en = 1; addr = a; size = s;
    @(negedge clk); rd_en = 0; size = 4;
    chk(rdata == exp, tag, 64'(rdata), 64'(exp));
  endtask

  task automatic rd_idx(logic [7:0] idx, logic [31:0] exp, string tag);
    wr(12'h000, {24'd0, idx});
    rd(12'h010, exp, tag);
  endtask

  task automatic ro(int p, bit dlv, bit rirr);
    @(negedge clk); ro_we[p] = 1; ro_dlv[p] = dlv; ro_rirr[p] = rirr;
    @(negedge clk); ro_we = 0; ro_dlv = 0; ro_rirr = 0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk(rdata == 0 && !rescan && !eoi_valid, "R1 outputs", 64'(rdata), 0);
    chk(entry[63:0] == 64'h10000 && entry[64*23 +: 64] == 64'h10000, "R1 entries",
        entry[63:0], 64'h10000);
    rd(12'h000, 32'h0, "R1 index");
    rd_idx(8'h00, 32'h0, "R1 id");

    rd_idx(8'h01, 32'h0017_0020, "R6 version");
    rd(12'h000, 32'h01, "R2 index readback");
    wr(12'h000, 32'h0000_01A5, 3'd1);
    rd(12'h000, 32'hA5, "R2 narrow index write");

    wr(12'h000, 32'h00);
    wr(12'h010, 32'h0A00_0000);
    rd(12'h010, 32'h0A00_0000, "R5 id write");
    rd_idx(8'h02, 32'h0A00_0000, "R5 arb mirror");
    wr(12'h010, 32'h0500_0000);
    rd_idx(8'h00, 32'h0A00_0000, "R5 arb write ignored");
    wr(12'h000, 32'h01);
    wr(12'h010, 32'h0300_0000);
    rd(12'h010, 32'h0017_0020, "R5 version write ignored");
    rd_idx(8'h00, 32'h0A00_0000, "R5 id after version write");

    wr(12'h000, 32'h10);
    wr(12'h010, 32'h0000_D035);
    rd(12'h010, 32'h0000_8035, "R8 status bits not written");
    ro(0, 1, 1);
    rd(12'h010, 32'h0000_D035, "R8 status set externally");
    wr(12'h010, 32'h0000_0022);
    rd(12'h010, 32'h0000_1022, "R9 edge clears remote irr");
    ro(0, 1, 1);
    rd(12'h010, 32'h0000_1022, "R9 edge blocks remote irr");

    rd_idx(8'h11, 32'h0, "R7 upper half reset");
    wr(12'h010, 32'hFF00_0000);
    rd(12'h010, 32'hFF00_0000, "R7 upper half");
    rd_idx(8'h10, 32'h0000_1022, "R7 lower half untouched");
    wr(12'h000, 32'h3F);
    wr(12'h010, 32'h1234_5678);
    rd(12'h010, 32'h1234_5678, "R7 last entry upper");
    rd_idx(8'h3E, 32'h0001_0000, "R7 last entry lower");
    wr(12'h000, 32'h40);
    wr(12'h010, 32'hDEAD_BEEF);
    rd(12'h010, 32'h0, "R7 out of range");
    chk(entry[64*23 +: 64] == 64'h1234_5678_0001_0000, "R7 no spill",
        entry[64*23 +: 64], 64'h1234_5678_0001_0000);

    wr(12'h000, 32'h10);
    wr(12'h010, 32'h0000_00FF, 3'd2);
    rd(12'h010, 32'h0, "R4 narrow read", 3'd2);
    rd(12'h010, 32'h0000_1022, "R4 narrow write ignored");

    rd(12'h110, 32'h0000_1022, "R3 alias data port");
    wr(12'hF00, 32'h11);
    rd(12'h000, 32'h11, "R3 alias index");

    wr(12'h040, 32'h0000_005A);
    chk(eoi_valid && eoi_vector == 8'h5A, "R11 eoi strobe", {eoi_valid, eoi_vector}, 9'h15A);
    wr(12'h040, 32'h0000_0033, 3'd1);
    chk(!eoi_valid, "R11 narrow eoi", 64'(eoi_valid), 0);

    rd(12'h020, 32'h0, "R12 unmapped offset");

    wr(12'h000, 32'h1A);
    wr(12'h010, 32'h0000_8000);
    ro(5, 0, 1);
    wr(12'h010, 32'h0000_8041);
    rd(12'h010, 32'h0000_C041, "R8 level remote irr kept");
    wr(12'h010, 32'h0000_0041);
    rd(12'h010, 32'h0000_0041, "R9 switch to edge");

    repeat (2) @(negedge clk);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++; fails++;
      $display("FAIL watchdog R12 act=hung exp=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule